// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block takes a serial line and turns each character into a parallel byte that a processor collects from a receive buffer. Every frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop bit. The line is sampled by a receive clock, given as a one-cycle enable `rx_tick`. That clock runs at 1, 16 or 64 times the baud rate, as chosen by `rate_sel`. In the two oversampled rates, a falling edge is checked a second time at the middle of the start bit. This rejects short glitches.

When a character is complete it moves into the buffer and `rx_ready` rises. A one-cycle `rd_pulse` from the processor clears `rx_ready`. Parity, framing and overrun problems set error flags that stay set until a one-cycle `err_clr` pulse. Reception only runs while `rx_en` is high.

The control is one state machine with these states:
- **HUNT**: waits for a low sample on an enabled tick.
- **START**: confirms the start bit at mid-bit. This state exists only for the 16x and 64x rates.
- **DATA**: samples each data bit.
- **PARITY**: samples the parity bit.
- **STOP**: samples the stop bit and delivers the character.

Its transitions are:
- HUNT→START when a low sample is seen at an oversampled rate.
- HUNT→DATA when a low sample is seen at the 1x rate.
- START→HUNT on a false start.
- START→DATA when the start bit is confirmed.
- DATA→PARITY after the last data bit, when parity is enabled.
- DATA→STOP after the last data bit, when parity is disabled.
- PARITY→STOP after the parity sample.
- STOP→HUNT after delivery.
- any state→HUNT whenever `rx_en` is low.

Top module: `serial_rx_core`

## Requirements
- R1: While `rst` is high and right after it falls, `rx_ready`, `err_parity`, `err_overrun`, `err_frame` and `rx_data` are all zero and the machine is hunting.
- R2: At 16x (`rate_sel`=10), a frame is sampled at mid-bit with the LSB first. `rx_ready` rises once the stop bit has been sampled, and `rx_data` then holds the character.
- R3: `rate_sel`=00 or 01 selects 1 receive tick per bit, 10 selects 16 ticks per bit and 11 selects 64 ticks per bit. Frames sent at each of these rates are received correctly.
- R4: `word_len` 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits. Buffer bits above the word length read as zero.
- R5: When `par_en`=1, one parity bit follows the data. `par_odd`=0 selects even parity and 1 selects odd parity. A mismatch sets `err_parity`.
- R6: A stop bit sampled low sets `err_frame`, and the character is still delivered with `rx_ready` set.
- R7: If a character completes while `rx_ready` is still set and no read happens in that cycle, the new character overwrites the buffer and `err_overrun` is set.
- R8: At 16x or 64x, a low pulse that has ended by mid-start-bit is treated as a false start. Nothing is delivered, and the receiver goes back to hunting and receives the next frame correctly.
- R9: `rd_pulse` clears only `rx_ready`. The error flags stay set until `err_clr`, which clears all three of them.
- R10: Dropping `rx_en` in the middle of a frame abandons it. No character is delivered, no flag is set, and the next frame received after re-enabling is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| rx_tick | input | 1 | Receive clock enable, one pulse per sample period |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receive enable |
| rate_sel | input | 2 | Ticks per bit: 00/01=1, 10=16, 11=64 |
| word_len | input | 2 | Data bits: 5 + value |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_pulse | input | 1 | Processor read of the buffer, clears rx_ready |
| err_clr | input | 1 | Clears all error flags |
| rx_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | Character available |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_frame | output | 1 | Sticky framing error |

## Verification
The properties assume that `rate_sel`, `word_len`, `par_en` and `par_odd` stay stable while a frame is in progress. They also assume that `rd_pulse` and `err_clr` are single-cycle pulses. The bench changes the format settings only while the line is idle and the machine is hunting, and it issues reads and clears for exactly one clock. It holds `rx_tick` high so that every clock is one sample period. It generates each bit as exactly one, sixteen or sixty-four clocks of line level, so the mid-bit samples fall well inside each bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    localparam int DIV_W = 6;

    // Last counter value of a full bit period for each rate code.
    function automatic logic [DIV_W-1:0] bit_last(input logic [1:0] rate);
        logic [DIV_W-1:0] v;
        unique case (rate)
            2'b11:   v = DIV_W'(63);
            2'b10:   v = DIV_W'(15);
            default: v = '0;
        endcase
        return v;
    endfunction

    // Last counter value of half a bit period (start-bit centre).
    function automatic logic [DIV_W-1:0] half_last(input logic [1:0] rate);
        logic [DIV_W-1:0] v;
        unique case (rate)
            2'b11:   v = DIV_W'(31);
            2'b10:   v = DIV_W'(7);
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic is_oversampled(input logic [1:0] rate);
        return rate[1];
    endfunction

endpackage

// File: rtl/serial_rx_baud.sv
module serial_rx_baud #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] half_lim,
    input  logic [CNT_W-1:0] full_lim,
    output logic             half_hit,
    output logic             full_hit
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == full_lim) ? '0 : cnt + 1'b1;
        end
    end

    assign half_hit = tick && (cnt == half_lim);
    assign full_hit = tick && (cnt == full_lim);

endmodule

// File: rtl/serial_rx_shift.sv
module serial_rx_shift #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic              rxd,
    input  logic [IDX_W-1:0]  last_idx,
    output logic [DATA_W-1:0] data,
    output logic              last_bit
);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            data <= '0;
            idx  <= '0;
        end else if (sample) begin
            data[idx] <= rxd;
            idx       <= idx + 1'b1;
        end
    end

    assign last_bit = sample && (idx == last_idx);

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              deliver,
    input  logic [DATA_W-1:0] char_in,
    input  logic              par_bad,
    input  logic              stop_bad,
    input  logic              rd,
    input  logic              clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_frame
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
        end else if (deliver) begin
            rx_data  <= char_in;
            rx_ready <= 1'b1;
        end else if (rd) begin
            rx_ready <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
            err_frame   <= 1'b0;
        end else begin
            if (clr) begin
                err_parity  <= 1'b0;
                err_overrun <= 1'b0;
                err_frame   <= 1'b0;
            end
            if (deliver && par_bad)             err_parity  <= 1'b1;
            if (deliver && stop_bad)            err_frame   <= 1'b1;
            if (deliver && rx_ready && !rd)     err_overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic [1:0]        rate_sel,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rd_pulse,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_frame
);

    localparam int IDX_W   = $clog2(DATA_W);
    localparam int MIN_IDX = DATA_W - (1 << LEN_W);

    rx_state_t state, state_nx;

    logic              cnt_restart;
    logic              half_hit, full_hit;
    logic              sh_clear, sh_sample, last_bit;
    logic [DATA_W-1:0] sh_data;
    logic              par_capture, par_bad_q;
    logic              deliver;
    logic [IDX_W-1:0]  last_idx;

    assign last_idx = IDX_W'(MIN_IDX) + IDX_W'(word_len);

    serial_rx_baud #(.CNT_W(DIV_W)) u_baud (
        .clk      (clk),
        .rst      (rst),
        .restart  (cnt_restart),
        .tick     (rx_tick),
        .half_lim (half_last(rate_sel)),
        .full_lim (bit_last(rate_sel)),
        .half_hit (half_hit),
        .full_hit (full_hit)
    );

    serial_rx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (sh_clear),
        .sample   (sh_sample),
        .rxd      (rxd),
        .last_idx (last_idx),
        .data     (sh_data),
        .last_bit (last_bit)
    );

    serial_rx_status #(.DATA_W(DATA_W)) u_status (
        .clk         (clk),
        .rst         (rst),
        .deliver     (deliver),
        .char_in     (sh_data),
        .par_bad     (par_en && par_bad_q),
        .stop_bad    (!rxd),
        .rd          (rd_pulse),
        .clr         (err_clr),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .err_parity  (err_parity),
        .err_overrun (err_overrun),
        .err_frame   (err_frame)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_HUNT;
        else     state <= state_nx;
    end

    // Parity check result, captured at the parity-bit sample
    always_ff @(posedge clk) begin
        if (rst || sh_clear)  par_bad_q <= 1'b0;
        else if (par_capture) par_bad_q <= ((^sh_data) ^ rxd) != par_odd;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (!rx_en) begin
            state_nx = ST_HUNT;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (rx_tick && !rxd)
                        state_nx = is_oversampled(rate_sel) ? ST_START : ST_DATA;
                end
                ST_START: begin
                    if (half_hit) state_nx = rxd ? ST_HUNT : ST_DATA;
                end
                ST_DATA: begin
                    if (last_bit) state_nx = par_en ? ST_PARITY : ST_STOP;
                end
                ST_PARITY: begin
                    if (full_hit) state_nx = ST_STOP;
                end
                ST_STOP: begin
                    if (full_hit) state_nx = ST_HUNT;
                end
                default: state_nx = ST_HUNT;
            endcase
        end
    end

    // Output / strobe logic
    always_comb begin
        cnt_restart = 1'b0;
        sh_clear    = 1'b0;
        sh_sample   = 1'b0;
        par_capture = 1'b0;
        deliver     = 1'b0;
        unique case (state)
            ST_HUNT: begin
                cnt_restart = 1'b1;
                sh_clear    = 1'b1;
            end
            ST_START: begin
                cnt_restart = half_hit;
            end
            ST_DATA: begin
                sh_sample = rx_en && full_hit;
            end
            ST_PARITY: begin
                par_capture = rx_en && full_hit;
            end
            ST_STOP: begin
                deliver = rx_en && full_hit;
            end
            default: begin
                cnt_restart = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker
    import serial_rx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      rx_en,
    input logic      rd_pulse,
    input logic      err_clr,
    input logic      deliver,
    input logic      rx_ready,
    input logic      err_parity,
    input logic      err_overrun,
    input logic      err_frame,
    input rx_state_t state
);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rx_ready && !err_parity && !err_overrun && !err_frame && state == ST_HUNT));

    a_r2_ready_after_deliver: assert property (@(posedge clk) disable iff (rst)
        deliver |=> rx_ready);

    a_r7_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (deliver && rx_ready && !rd_pulse) |=> err_overrun);

    a_r9_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (rd_pulse && !deliver) |=> !rx_ready);

    a_r9_parity_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_parity && !err_clr) |=> err_parity);

    a_r9_frame_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_frame && !err_clr) |=> err_frame);

    a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !deliver) |=> (!err_parity && !err_overrun && !err_frame));

    a_r10_disable_hunts: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (state == ST_HUNT && !deliver));

endmodule

bind serial_rx_core serial_rx_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_en       (rx_en),
    .rd_pulse    (rd_pulse),
    .err_clr     (err_clr),
    .deliver     (deliver),
    .rx_ready    (rx_ready),
    .err_parity  (err_parity),
    .err_overrun (err_overrun),
    .err_frame   (err_frame),
    .state       (state)
);

// File: tb/serial_rx_core_bench.sv
`timescale 1ns/1ps
module serial_rx_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] rate_sel = 2'b10;
    logic [1:0] word_len = 2'b11;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_pulse = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_parity, err_overrun, err_frame;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_rx_core u_serial_rx_core (
        .clk(clk), .rst(rst), .rx_tick(rx_tick), .rxd(rxd), .rx_en(rx_en),
        .rate_sel(rate_sel), .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
        .rd_pulse(rd_pulse), .err_clr(err_clr), .rx_data(rx_data), .rx_ready(rx_ready),
        .err_parity(err_parity), .err_overrun(err_overrun), .err_frame(err_frame)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int ticks_per_bit(input logic [1:0] r);
        return (r == 2'b11) ? 64 : (r == 2'b10) ? 16 : 1;
    endfunction

    task automatic drive_bit(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic stop_lvl);
        int  f = ticks_per_bit(rate_sel);
        int  nb = 5 + int'(word_len);
        logic p = par_odd;
        for (int i = 0; i < nb; i++) p = p ^ d[i];
        drive_bit(1'b0, f);
        for (int i = 0; i < nb; i++) drive_bit(d[i], f);
        if (par_en) drive_bit(p ^ flip_par, f);
        drive_bit(stop_lvl, f);
        rxd = 1'b1;
        repeat (f + 4) @(negedge clk);
    endtask

    task automatic do_read();
        rd_pulse = 1'b1; @(negedge clk); rd_pulse = 1'b0; @(negedge clk);
    endtask

    task automatic do_clear();
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "ready in reset", rx_ready, 0);
        check("R1", "errors in reset", {err_parity, err_overrun, err_frame}, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "data after reset", rx_data, 0);
        check("R1", "ready after reset", rx_ready, 0);
    endtask

    task automatic t_basic16();
        rate_sel = 2'b10; word_len = 2'b11; par_en = 1'b0;
        send_frame(8'hA5, 1'b0, 1'b1);
        check("R2", "16x ready", rx_ready, 1);
        check("R2", "16x data", rx_data, 8'hA5);
        check("R2", "16x no errors", {err_parity, err_overrun, err_frame}, 0);
        do_read();
    endtask

    task automatic t_rates();
        rate_sel = 2'b01; word_len = 2'b11; par_en = 1'b0;
        send_frame(8'h3C, 1'b0, 1'b1);
        check("R3", "1x data", rx_data, 8'h3C);
        check("R3", "1x ready", rx_ready, 1);
        do_read();
        rate_sel = 2'b00;
        send_frame(8'h81, 1'b0, 1'b1);
        check("R3", "rate 00 data", rx_data, 8'h81);
        do_read();
        rate_sel = 2'b11;
        send_frame(8'h6E, 1'b0, 1'b1);
        check("R3", "64x data", rx_data, 8'h6E);
        check("R3", "64x ready", rx_ready, 1);
        do_read();
    endtask

    task automatic t_lengths();
        rate_sel = 2'b01; par_en = 1'b0; word_len = 2'b11;
        send_frame(8'hFF, 1'b0, 1'b1);
        do_read();
        word_len = 2'b00;
        send_frame(8'hF5, 1'b0, 1'b1);
        check("R4", "5-bit data, high bits zero", rx_data, 8'h15);
        do_read();
        word_len = 2'b01;
        send_frame(8'hEA, 1'b0, 1'b1);
        check("R4", "6-bit data", rx_data, 8'h2A);
        do_read();
        word_len = 2'b10;
        rate_sel = 2'b10;
        send_frame(8'hD3, 1'b0, 1'b1);
        check("R4", "7-bit data", rx_data, 8'h53);
        check("R4", "7-bit no errors", {err_parity, err_overrun, err_frame}, 0);
        do_read();
    endtask

    task automatic t_parity();
        rate_sel = 2'b10; word_len = 2'b10; par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h55, 1'b0, 1'b1);
        check("R5", "even good parity flag", err_parity, 0);
        check("R5", "even data", rx_data, 8'h55);
        do_read();
        send_frame(8'h55, 1'b1, 1'b1);
        check("R5", "even bad parity flag", err_parity, 1);
        do_read();
        do_clear();
        par_odd = 1'b1; word_len = 2'b11;
        send_frame(8'h07, 1'b0, 1'b1);
        check("R5", "odd good parity flag", err_parity, 0);
        do_read();
        send_frame(8'h07, 1'b1, 1'b1);
        check("R5", "odd bad parity flag", err_parity, 1);
        do_read();
        do_clear();
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_framing();
        rate_sel = 2'b10; word_len = 2'b11;
        send_frame(8'h42, 1'b0, 1'b0);
        repeat (40) @(negedge clk);
        check("R6", "frame flag", err_frame, 1);
        check("R6", "char delivered", rx_ready, 1);
        check("R6", "data", rx_data, 8'h42);
        do_read();
        check("R9", "read keeps frame flag", err_frame, 1);
        do_clear();
        check("R9", "clear drops frame flag", err_frame, 0);
    endtask

    task automatic t_overrun();
        rate_sel = 2'b01; word_len = 2'b11;
        send_frame(8'h11, 1'b0, 1'b1);
        send_frame(8'h22, 1'b0, 1'b1);
        check("R7", "overrun flag", err_overrun, 1);
        check("R7", "buffer overwritten", rx_data, 8'h22);
        do_read();
        check("R9", "read clears ready", rx_ready, 0);
        check("R9", "read keeps overrun", err_overrun, 1);
        do_clear();
        check("R9", "clear drops overrun", err_overrun, 0);
    endtask

    task automatic t_false_start();
        rate_sel = 2'b10; word_len = 2'b11;
        drive_bit(1'b0, 4);
        drive_bit(1'b1, 60);
        check("R8", "no char after glitch", rx_ready, 0);
        check("R8", "no flags after glitch", {err_parity, err_overrun, err_frame}, 0);
        send_frame(8'hC3, 1'b0, 1'b1);
        check("R8", "frame after glitch", rx_data, 8'hC3);
        do_read();
    endtask

    task automatic t_enable();
        rate_sel = 2'b10; word_len = 2'b11;
        drive_bit(1'b0, 16);
        drive_bit(1'b1, 16);
        drive_bit(1'b0, 8);
        rx_en = 1'b0;
        rxd = 1'b1;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        repeat (300) @(negedge clk);
        check("R10", "abandoned frame not delivered", rx_ready, 0);
        check("R10", "abandoned frame no flags", {err_parity, err_overrun, err_frame}, 0);
        send_frame(8'h5A, 1'b0, 1'b1);
        check("R10", "frame after re-enable", rx_data, 8'h5A);
        do_read();
    endtask

    initial begin
        t_reset();
        t_basic16();
        t_rates();
        t_lengths();
        t_parity();
        t_framing();
        t_overrun();
        t_false_start();
        t_enable();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule